// File: doc/BRIEF.md
# Multi-Mode Serial Receive Channel

This block is the receive side of a configurable serial port. It turns an incoming bit stream into bytes and stores them in a small receive FIFO. The consumer reads the FIFO through a show-ahead pop interface. Four framing modes are supported: 8-bit asynchronous, 7-bit asynchronous, clocked slave (the far end drives the bit clock) and clocked master (the block drives the bit clock). The asynchronous modes use a 16x oversampling tick supplied from outside the block.

Software configures the channel through a single control byte. The mode and frame fields are accepted only while receive is disabled. Clearing the enable bit also empties the FIFO. Three sticky error flags report parity failures, framing failures and FIFO overruns. Writing 1 to a flag's clear bit resets that flag.

Top module: `sio_rx_channel`

## Requirements
- R1: After reset, receive is disabled, the FIFO is empty (`rx_valid`=0), all three error flags are 0 and `sclk_out` is 0.
- R2: Control byte layout: bit 6 is the receive enable, bit 5 enables parity, bit 4 selects odd parity (0 = even), bit 3 selects two stop bits and bits [1:0] hold the mode (11 = 8-bit async, 10 = 7-bit async, 01 = clocked slave, 00 = clocked master). In 8-bit async mode, a frame is a low start bit, then 8 data bits LSB first, then an optional parity bit and one or two high stop bits. Each received byte is placed in the FIFO in arrival order.
- R3: In 7-bit async mode, only 7 data bits are received, and bit 7 of the stored byte is 0.
- R4: With parity enabled in an async mode, the received parity bit is compared with the even or odd rule over the data bits, and a mismatch sets `par_err`. The byte is still stored.
- R5: A stop bit sampled low sets `frm_err`. When two stop bits are selected, both are checked.
- R6: A falling edge on `sdi` starts a frame only if the line is still low at the middle of the start bit. Otherwise the receiver returns to idle and stores nothing.
- R7: Each error flag stays set until 1 is written to its own bit of `err_clr` (bit 0 parity, bit 1 framing, bit 2 overrun) with `err_clr_we` high. Writing 1 to another flag's bit leaves it set.
- R8: A byte that completes while the FIFO holds `FIFO_DEPTH` entries is dropped and sets `ovr_err`. The stored bytes are kept unchanged.
- R9: Writing 0 to the receive enable discards all bytes held in the FIFO.
- R10: A control write made while receive is enabled changes only the enable bit. The mode, parity and stop settings keep their values.
- R11: In clocked slave mode, `sdi` is sampled on each rising edge of `sclk_in`, LSB first, and a byte is stored after every 8 edges. The parity setting has no effect.
- R12: In clocked master mode, `sclk_out` toggles on each `os_tick` and `sdi` is sampled on its rising edge. The clock halts low at a byte boundary while the FIFO is full. In every other mode, and while disabled, `sclk_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte value |
| err_clr_we | input | 1 | Error flag clear strobe |
| err_clr | input | 3 | Write-1-to-clear mask: parity, framing, overrun |
| os_tick | input | 1 | Oversampling / bit clock tick, one cycle wide |
| sdi | input | 1 | Serial data in |
| sclk_in | input | 1 | Serial bit clock from the far end (slave mode) |
| sclk_out | output | 1 | Serial bit clock driven in master mode |
| pop | input | 1 | Remove the head byte from the FIFO |
| rx_valid | output | 1 | FIFO holds at least one byte |
| rx_data | output | 8 | Head byte of the FIFO |
| par_err | output | 1 | Sticky parity error flag |
| frm_err | output | 1 | Sticky framing error flag |
| ovr_err | output | 1 | Sticky overrun flag |

## Verification
The hardest states to reach are the ones where the FIFO is already full when a new byte lands: an async overrun, and the master clock stalling at a byte boundary. The scoreboard monitor normally drains every byte as soon as it appears, so it never lets the FIFO fill. To reach these states, the stimulus switches the monitor off, pushes more frames than the FIFO can hold (or lets the master clock run on its own), checks the flags and clock activity, and then drains the stored bytes by hand. A second stop bit held low and a start glitch shorter than half a bit are driven deliberately, to reach the framing and false-start paths.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

  typedef enum logic [1:0] {
    MODE_MASTER = 2'b00,
    MODE_SLAVE  = 2'b01,
    MODE_ASYNC7 = 2'b10,
    MODE_ASYNC8 = 2'b11
  } rx_mode_e;

  typedef struct packed {
    logic     par_en;
    logic     par_odd;
    logic     two_stop;
    rx_mode_e mode;
  } rx_cfg_t;

  localparam int CB_EN    = 6;
  localparam int CB_PEN   = 5;
  localparam int CB_PODD  = 4;
  localparam int CB_STOP2 = 3;

endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full,
  output logic         overrun
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [AW:0]   cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign overrun = push & full & ~flush;
  assign rd_data = mem[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_push) wr_n = (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_n = (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_n = cnt_q + 1'b1;
        2'b01:   cnt_n = cnt_q - 1'b1;
        default: cnt_n = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  // R8: a push into a full FIFO without a pop leaves the occupancy unchanged
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !flush) |=> (cnt_q == $past(cnt_q)));

  // R9: a flush cycle leaves the FIFO empty
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/sio_rx_async.sv
module sio_rx_async #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       seven_bit,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       two_stop,
  input  logic       tick,
  input  logic       sdi,
  output logic       push,
  output logic [7:0] push_data,
  output logic       par_fail,
  output logic       frm_fail
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {A_IDLE, A_START, A_DATA, A_PAR, A_STOP} astate_e;

  astate_e       st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [2:0]    bi_q, bi_n;
  logic [7:0]    sh_q, sh_n;
  logic          stop2_q, stop2_n;
  logic          prev_q;
  logic [2:0]    last_bit;

  assign last_bit  = seven_bit ? 3'd6 : 3'd7;
  assign push_data = seven_bit ? {1'b0, sh_q[6:0]} : sh_q;

  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    bi_n     = bi_q;
    sh_n     = sh_q;
    stop2_n  = stop2_q;
    push     = 1'b0;
    par_fail = 1'b0;
    frm_fail = 1'b0;
    if (!en) begin
      st_n  = A_IDLE;
      cnt_n = '0;
    end else begin
      case (st_q)
        A_IDLE: begin
          if (prev_q && !sdi) begin
            st_n  = A_START;
            cnt_n = '0;
          end
        end
        A_START: if (tick) begin
          if (cnt_q == MID) begin
            cnt_n = '0;
            if (!sdi) begin
              st_n = A_DATA;
              bi_n = '0;
              sh_n = '0;
            end else begin
              st_n = A_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        A_DATA: if (tick) begin
          if (cnt_q == LAST) begin
            cnt_n     = '0;
            sh_n[bi_q] = sdi;
            if (bi_q == last_bit) begin
              st_n    = par_en ? A_PAR : A_STOP;
              stop2_n = two_stop;
            end else begin
              bi_n = bi_q + 1'b1;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        A_PAR: if (tick) begin
          if (cnt_q == LAST) begin
            cnt_n    = '0;
            par_fail = (sdi != ((^sh_q) ^ par_odd));
            st_n     = A_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        A_STOP: if (tick) begin
          if (cnt_q == LAST) begin
            cnt_n    = '0;
            frm_fail = ~sdi;
            if (stop2_q) begin
              stop2_n = 1'b0;
            end else begin
              push = 1'b1;
              st_n = A_IDLE;
            end
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: st_n = A_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= A_IDLE;
      cnt_q   <= '0;
      bi_q    <= '0;
      sh_q    <= '0;
      stop2_q <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      bi_q    <= bi_n;
      sh_q    <= sh_n;
      stop2_q <= stop2_n;
      prev_q  <= sdi;
    end
  end

  // R5: bytes leave only from the stop-bit phase
  p_push_in_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (st_q == A_STOP));

  // R6: a line found high at mid start bit sends the receiver back to idle
  p_false_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_q == A_START && tick && cnt_q == MID && sdi) |=> (st_q == A_IDLE));

endmodule

// File: rtl/sio_rx_sync.sv
module sio_rx_sync (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       master,
  input  logic       tick,
  input  logic       sclk_in,
  input  logic       sdi,
  input  logic       fifo_full,
  output logic       sclk_out,
  output logic       push,
  output logic [7:0] push_data
);
  logic [2:0] bc_q, bc_n;
  logic [6:0] sh_q, sh_n;
  logic       sclk_q, sclk_n;
  logic       sprev_q;
  logic       may_rise, sample;

  assign may_rise  = ~((bc_q == 3'd0) & fifo_full);
  assign sample    = master ? (tick & ~sclk_q & may_rise) : (sclk_in & ~sprev_q);
  assign sclk_out  = sclk_q;
  assign push_data = {sdi, sh_q};

  always_comb begin
    bc_n   = bc_q;
    sh_n   = sh_q;
    sclk_n = sclk_q;
    push   = 1'b0;
    if (!en) begin
      bc_n   = '0;
      sclk_n = 1'b0;
    end else begin
      if (master && tick) begin
        if (sclk_q)        sclk_n = 1'b0;
        else if (may_rise) sclk_n = 1'b1;
      end
      if (!master) sclk_n = 1'b0;
      if (sample) begin
        if (bc_q == 3'd7) begin
          push = 1'b1;
          bc_n = '0;
        end else begin
          sh_n[bc_q] = sdi;
          bc_n       = bc_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q    <= '0;
      sh_q    <= '0;
      sclk_q  <= 1'b0;
      sprev_q <= 1'b0;
    end else begin
      bc_q    <= bc_n;
      sh_q    <= sh_n;
      sclk_q  <= sclk_n;
      sprev_q <= sclk_in;
    end
  end

  // R12: in master mode the clock only rises on a tick
  p_rise_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $past(tick));

endmodule

// File: rtl/sio_rx_channel.sv
module sio_rx_channel
  import sio_rx_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_we,
  input  logic [7:0] ctrl_wdata,
  input  logic       err_clr_we,
  input  logic [2:0] err_clr,
  input  logic       os_tick,
  input  logic       sdi,
  input  logic       sclk_in,
  output logic       sclk_out,
  input  logic       pop,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       par_err,
  output logic       frm_err,
  output logic       ovr_err
);
  localparam int SS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [1:0]    rst_pipe;
  logic          rst_ni;
  logic [SS-1:0] sdi_pipe, sclk_pipe;
  logic          sdi_s, sclk_s;

  logic    en_q, en_n;
  rx_cfg_t cfg_q, cfg_n;
  logic    pe_q, pe_n, fe_q, fe_n, oe_q, oe_n;
  logic    unused_cb;

  logic       a_en, s_en, is_master;
  logic       a_push, a_pf, a_ff;
  logic [7:0] a_data;
  logic       s_push;
  logic [7:0] s_data;
  logic       f_push, f_empty, f_full, f_ovr;
  logic [7:0] f_data;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sdi_pipe  <= '1;
      sclk_pipe <= '0;
    end else begin
      sdi_pipe  <= {sdi_pipe[SS-2:0], sdi};
      sclk_pipe <= {sclk_pipe[SS-2:0], sclk_in};
    end
  end
  assign sdi_s  = sdi_pipe[SS-1];
  assign sclk_s = sclk_pipe[SS-1];

  assign unused_cb = ctrl_wdata[7] ^ ctrl_wdata[2];

  always_comb begin
    en_n  = en_q;
    cfg_n = cfg_q;
    if (ctrl_we) begin
      en_n = ctrl_wdata[CB_EN];
      if (!en_q) begin
        cfg_n.par_en   = ctrl_wdata[CB_PEN];
        cfg_n.par_odd  = ctrl_wdata[CB_PODD];
        cfg_n.two_stop = ctrl_wdata[CB_STOP2];
        cfg_n.mode     = rx_mode_e'(ctrl_wdata[1:0]);
      end
    end
    pe_n = (pe_q & ~(err_clr_we & err_clr[0])) | a_pf;
    fe_n = (fe_q & ~(err_clr_we & err_clr[1])) | a_ff;
    oe_n = (oe_q & ~(err_clr_we & err_clr[2])) | f_ovr;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cfg_q <= '0;
      pe_q  <= 1'b0;
      fe_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      en_q  <= en_n;
      cfg_q <= cfg_n;
      pe_q  <= pe_n;
      fe_q  <= fe_n;
      oe_q  <= oe_n;
    end
  end

  assign a_en      = en_q & cfg_q.mode[1];
  assign s_en      = en_q & ~cfg_q.mode[1];
  assign is_master = (cfg_q.mode == MODE_MASTER);

  sio_rx_async #(.OSR(OSR)) u_async (
    .clk       (clk),
    .rst_n     (rst_ni),
    .en        (a_en),
    .seven_bit (cfg_q.mode == MODE_ASYNC7),
    .par_en    (cfg_q.par_en),
    .par_odd   (cfg_q.par_odd),
    .two_stop  (cfg_q.two_stop),
    .tick      (os_tick),
    .sdi       (sdi_s),
    .push      (a_push),
    .push_data (a_data),
    .par_fail  (a_pf),
    .frm_fail  (a_ff)
  );

  sio_rx_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_ni),
    .en        (s_en),
    .master    (is_master),
    .tick      (os_tick),
    .sclk_in   (sclk_s),
    .sdi       (sdi_s),
    .fifo_full (f_full),
    .sclk_out  (sclk_out),
    .push      (s_push),
    .push_data (s_data)
  );

  assign f_push = a_en ? a_push : s_push;

  sio_rx_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_ni),
    .flush     (~en_q),
    .push      (f_push),
    .push_data (a_en ? a_data : s_data),
    .pop       (pop),
    .rd_data   (f_data),
    .empty     (f_empty),
    .full      (f_full),
    .overrun   (f_ovr)
  );

  assign rx_valid = ~f_empty;
  assign rx_data  = f_data;
  assign par_err  = pe_q;
  assign frm_err  = fe_q;
  assign ovr_err  = oe_q;

  // R10: configuration holds while receive is enabled
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    en_q |=> $stable(cfg_q));

  // R7: parity flag persists unless its own clear bit is written
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (par_err && !(err_clr_we && err_clr[0])) |=> par_err);

  // R3: stored bytes in 7-bit mode have a clear top bit
  p_msb_zero_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_valid && cfg_q.mode == MODE_ASYNC7) |-> !rx_data[7]);

  // R11: no parity error can arise in a clocked mode
  p_no_clocked_parity_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (en_q && !cfg_q.mode[1]) |=> !$rose(par_err));

  // R12: serial clock stays low outside enabled master mode
  p_sclk_idle_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    (!en_q || cfg_q.mode != MODE_MASTER) |=> !sclk_out);

endmodule

// File: tb/tb_sio_rx_channel.sv
module tb_sio_rx_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic       err_clr_we = 1'b0;
  logic [2:0] err_clr = '0;
  logic       os_tick = 1'b0;
  logic       sdi = 1'b1;
  logic       sclk_in = 1'b0;
  logic       sclk_out;
  logic       pop = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       par_err, frm_err, ovr_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  string cur_req = "R2";
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  sio_rx_channel dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .err_clr_we(err_clr_we), .err_clr(err_clr), .os_tick(os_tick), .sdi(sdi),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .pop(pop), .rx_valid(rx_valid),
    .rx_data(rx_data), .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  always @(negedge clk) os_tick = ~os_tick;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (pop) pop = 1'b0;
      else if (rx_valid) begin
        if (exp_q.size() == 0) check(1'b0, {cur_req, " unexpected byte"}, rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(rx_data == e, {cur_req, " scoreboard"}, rx_data, e);
        end
        pop = 1'b1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] cb(bit en, bit pe, bit po, bit ts, logic [1:0] m);
    return {1'b0, en, pe, po, ts, 1'b0, m};
  endfunction

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic clr(input logic [2:0] m);
    err_clr_we = 1'b1; err_clr = m;
    @(negedge clk);
    err_clr_we = 1'b0; err_clr = '0;
    @(negedge clk);
  endtask

  task automatic setup(input bit pe, input bit po, input bit ts, input logic [1:0] m);
    wr_ctrl(cb(0, pe, po, ts, m));
    wr_ctrl(cb(1, pe, po, ts, m));
  endtask

  task automatic bit_wait();
    repeat (32) @(negedge clk);
  endtask

  task automatic send_async(input logic [7:0] d, input int nbits, input bit pe, input bit po,
                            input bit bad_par, input int bad_stop, input int nstop, input bit expect_it);
    logic p;
    p = po;
    if (expect_it) exp_q.push_back(nbits == 7 ? {1'b0, d[6:0]} : d);
    sdi = 1'b0; bit_wait();
    for (int i = 0; i < nbits; i++) begin
      sdi = d[i]; p = p ^ d[i]; bit_wait();
    end
    if (pe) begin sdi = bad_par ? ~p : p; bit_wait(); end
    for (int s = 1; s <= nstop; s++) begin
      sdi = (bad_stop == s) ? 1'b0 : 1'b1; bit_wait();
    end
    sdi = 1'b1; bit_wait();
  endtask

  task automatic send_sync(input logic [7:0] d);
    exp_q.push_back(d);
    for (int i = 0; i < 8; i++) begin
      sdi = d[i];
      repeat (8) @(negedge clk);
      sclk_in = 1'b1;
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
    end
    repeat (16) @(negedge clk);
  endtask

  task automatic manual_pop(input logic [7:0] e, input string req);
    check(rx_valid && rx_data == e, req, rx_data, e);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      @(negedge clk); guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int tog;
    logic last;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    check(!rx_valid, "R1 rx_valid", rx_valid, 0);
    check({par_err, frm_err, ovr_err} == 3'b000, "R1 flags", {par_err, frm_err, ovr_err}, 0);
    check(!sclk_out, "R1 sclk_out", sclk_out, 0);

    mon_en = 1'b1;

    // R2 8-bit async, several patterns
    cur_req = "R2";
    setup(0, 0, 0, 2'b11);
    send_async(8'h5A, 8, 0, 0, 0, 0, 1, 1);
    send_async(8'hC3, 8, 0, 0, 0, 0, 1, 1);
    send_async(8'h00, 8, 0, 0, 0, 0, 1, 1);
    send_async(8'hFF, 8, 0, 0, 0, 0, 1, 1);
    drain();

    // R3 / R4 7-bit async with even parity
    cur_req = "R3";
    setup(1, 0, 0, 2'b10);
    send_async(8'h35, 7, 1, 0, 0, 0, 1, 1);
    send_async(8'hFF, 7, 1, 0, 0, 0, 1, 1);
    drain();
    check(!par_err, "R4 even good parity", par_err, 0);
    cur_req = "R4";
    send_async(8'h2B, 7, 1, 0, 1, 0, 1, 1);
    drain();
    check(par_err, "R4 even bad parity", par_err, 1);

    // R7 sticky, selective clear
    repeat (100) @(negedge clk);
    check(par_err, "R7 flag held", par_err, 1);
    clr(3'b110);
    check(par_err, "R7 other clear bits", par_err, 1);
    clr(3'b001);
    check(!par_err, "R7 cleared", par_err, 0);

    // R4 odd parity in 8-bit mode
    setup(1, 1, 0, 2'b11);
    send_async(8'h81, 8, 1, 1, 0, 0, 1, 1);
    drain();
    check(!par_err, "R4 odd good parity", par_err, 0);
    send_async(8'h7E, 8, 1, 1, 1, 0, 1, 1);
    drain();
    check(par_err, "R4 odd bad parity", par_err, 1);
    clr(3'b001);

    // R5 framing
    cur_req = "R5";
    setup(0, 0, 0, 2'b11);
    send_async(8'h3C, 8, 0, 0, 0, 1, 1, 1);
    drain();
    check(frm_err, "R5 single stop low", frm_err, 1);
    clr(3'b010);
    check(!frm_err, "R7 framing cleared", frm_err, 0);
    setup(0, 0, 1, 2'b11);
    send_async(8'h96, 8, 0, 0, 0, 0, 2, 1);
    drain();
    check(!frm_err, "R5 two good stops", frm_err, 0);
    send_async(8'h69, 8, 0, 0, 0, 2, 2, 1);
    drain();
    check(frm_err, "R5 second stop low", frm_err, 1);
    clr(3'b010);

    // R6 start glitch
    cur_req = "R6";
    sdi = 1'b0;
    repeat (6) @(negedge clk);
    sdi = 1'b1;
    repeat (600) @(negedge clk);
    check(!rx_valid, "R6 glitch stores nothing", rx_valid, 0);
    check(!frm_err, "R6 no framing error", frm_err, 0);

    // R10 config write while enabled ignored (stays 8-bit, two stop)
    cur_req = "R10";
    wr_ctrl(cb(1, 1, 0, 0, 2'b10));
    send_async(8'hF0, 8, 0, 0, 0, 0, 2, 1);
    drain();
    check(!frm_err && !par_err, "R10 settings kept", {par_err, frm_err}, 0);

    // R8 overrun
    cur_req = "R8";
    mon_en = 1'b0;
    send_async(8'h11, 8, 0, 0, 0, 0, 2, 0);
    send_async(8'h22, 8, 0, 0, 0, 0, 2, 0);
    send_async(8'h33, 8, 0, 0, 0, 0, 2, 0);
    send_async(8'h44, 8, 0, 0, 0, 0, 2, 0);
    check(!ovr_err, "R8 no overrun at depth", ovr_err, 0);
    send_async(8'h55, 8, 0, 0, 0, 0, 2, 0);
    check(ovr_err, "R8 overrun set", ovr_err, 1);
    manual_pop(8'h11, "R8 kept 0");
    manual_pop(8'h22, "R8 kept 1");
    manual_pop(8'h33, "R8 kept 2");
    manual_pop(8'h44, "R8 kept 3");
    check(!rx_valid, "R8 extra byte dropped", rx_valid, 0);
    clr(3'b100);
    check(!ovr_err, "R7 overrun cleared", ovr_err, 0);

    // R9 disable flushes
    cur_req = "R9";
    send_async(8'hA1, 8, 0, 0, 0, 0, 2, 0);
    send_async(8'hB2, 8, 0, 0, 0, 0, 2, 0);
    check(rx_valid, "R9 data present", rx_valid, 1);
    wr_ctrl(cb(0, 0, 0, 1, 2'b11));
    check(!rx_valid, "R9 flushed", rx_valid, 0);
    mon_en = 1'b1;

    // R11 clocked slave, parity setting ignored
    cur_req = "R11";
    setup(1, 1, 0, 2'b01);
    send_sync(8'hA6);
    send_sync(8'h3C);
    drain();
    check(!par_err && !frm_err, "R11 no errors", {par_err, frm_err}, 0);
    check(!sclk_out, "R12 sclk low in slave", sclk_out, 0);

    // R12 clocked master
    cur_req = "R12";
    mon_en = 1'b0;
    wr_ctrl(cb(0, 0, 0, 0, 2'b00));
    sdi = 1'b1;
    repeat (8) @(negedge clk);
    wr_ctrl(cb(1, 0, 0, 0, 2'b00));
    tog = 0; last = sclk_out;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sclk_out != last) tog++;
      last = sclk_out;
    end
    check(tog > 0, "R12 clock runs", tog, 1);
    repeat (400) @(negedge clk);
    tog = 0; last = sclk_out;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sclk_out != last) tog++;
      last = sclk_out;
    end
    check(tog == 0 && !sclk_out, "R12 halted when full", tog, 0);
    check(!ovr_err, "R12 no overrun", ovr_err, 0);
    manual_pop(8'hFF, "R12 byte 0");
    manual_pop(8'hFF, "R12 byte 1");
    manual_pop(8'hFF, "R12 byte 2");
    manual_pop(8'hFF, "R12 byte 3");
    wr_ctrl(cb(0, 0, 0, 0, 2'b00));
    repeat (4) @(negedge clk);
    check(!sclk_out && !rx_valid, "R12 disabled idle", {sclk_out, rx_valid}, 0);

    check(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule